// File: doc/BRIEF.md
# Address-Aliased Event and Semaphore Bank

This block holds a bank of single-bit event flags and 32-bit counting semaphores behind a simple single-port register bus. The offset of a bus access selects two things at once: which entry is touched and which operation is applied to it. Four address windows map onto one shared counter array. A single bus write can therefore overwrite a counter, add to it or subtract from it. No software read-modify-write sequence is needed.

A separate window sets and clears the event flags. The block also drives the full flag vector and a per-counter nonzero vector continuously, so that waiting engines can poll them without bus traffic. Every request is answered one cycle later with a ready pulse, and read data is presented with that pulse.

Top module: `evsem_bank`

## Requirements
- R1: Offset bits [12:10] choose the window and bits [9:2] choose the entry (0 to 255); bits [1:0] are ignored. Window codes: 0 event, 1 to 3 reserved, 4 counter read, 5 counter overwrite, 6 counter add, 7 counter subtract. Accesses to different entries never disturb each other.
- R2: In the event window (offset 0x000 to 0x3FF), a write stores bit 0 of the write data into the addressed flag, so 1 sets it and 0 clears it. A read returns the flag in bit 0, with the upper bits zero. The flag vector appears on `evt_flags`, with bit i for entry i.
- R3: The read window (offset 0x1000) returns the current 32-bit counter value. Writes to this window leave all state unchanged.
- R4: A write to the overwrite window (offset 0x1400) replaces the addressed counter with the write data.
- R5: A write to the add window (offset 0x1800) adds the write data to the addressed counter, wrapping modulo 2^32.
- R6: A write to the subtract window (offset 0x1C00) subtracts the write data from the addressed counter, wrapping modulo 2^32.
- R7: The read, overwrite, add and subtract windows all act on the same 256 counters. A change made through one window is seen through the read window.
- R8: Offsets 0x400 to 0xFFF are reserved. Reads of these offsets return zero, and writes to them change no flag and no counter.
- R9: Reads of the overwrite, add and subtract windows return zero.
- R10: `bus_ready` is high in the cycle after each request and low otherwise. Read data is valid while `bus_ready` is high, and write responses carry zero. A read issued in the cycle right after an add or subtract returns the updated value.
- R11: Reset clears all flags and all counters. Bit i of `sem_nonzero` is high exactly when counter i is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset into the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion, one cycle after the request |
| evt_flags | output | 256 | Current event flags |
| sem_nonzero | output | 256 | Per-counter nonzero status |

## Verification
The hardest situation to reach is wrap-around at the 32-bit boundary, together with an add or subtract that is read back in the very next cycle. The stimulus issues back-to-back requests with no idle cycle between them. It drives a counter below zero with a subtract and then back across zero with an add, and reads the counter immediately after each step. The last entry (index 255) is aimed at through every window, including a read-only write and reserved-space writes that alias onto index 255. The stimulus then confirms that the flag and counter held there survive those writes.

// File: rtl/evsem_pkg.sv
package evsem_pkg;
    parameter int N_ENT = 256;
    parameter int DW    = 32;
    localparam int IDX_W = $clog2(N_ENT);
    localparam int WIN_W = 3;
    localparam int AW    = WIN_W + IDX_W + 2;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_EVT  = 3'd1,
        OP_SET  = 3'd2,
        OP_ADD  = 3'd3,
        OP_SUB  = 3'd4
    } wr_op_t;

    typedef enum logic [1:0] {
        RD_ZERO = 2'd0,
        RD_EVT  = 2'd1,
        RD_SEM  = 2'd2
    } rd_sel_t;

    typedef struct packed {
        logic [N_ENT-1:0]         ev;
        logic [N_ENT-1:0][DW-1:0] sem;
        logic [DW-1:0]            rdata;
        logic                     rdy;
    } bank_state_t;
endpackage

// File: rtl/evsem_decode.sv
module evsem_decode
    import evsem_pkg::*;
(
    input  logic             req,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    output logic [IDX_W-1:0] idx,
    output wr_op_t           wop,
    output rd_sel_t          rsel
);
    logic [WIN_W-1:0] win;

    assign win = addr[AW-1 -: WIN_W];
    assign idx = addr[IDX_W+1:2];

    always_comb begin
        wop  = OP_NONE;
        rsel = RD_ZERO;
        if (req && we) begin
            unique case (win)
                3'd0:    wop = OP_EVT;
                3'd5:    wop = OP_SET;
                3'd6:    wop = OP_ADD;
                3'd7:    wop = OP_SUB;
                default: wop = OP_NONE;
            endcase
        end else if (req) begin
            unique case (win)
                3'd0:    rsel = RD_EVT;
                3'd4:    rsel = RD_SEM;
                default: rsel = RD_ZERO;
            endcase
        end
    end
endmodule

// File: rtl/evsem_arith.sv
module evsem_arith
    import evsem_pkg::*;
(
    input  wr_op_t        wop,
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] operand,
    output logic          upd,
    output logic [DW-1:0] nxt
);
    always_comb begin
        upd = 1'b1;
        nxt = cur;
        unique case (wop)
            OP_SET:  nxt = operand;
            OP_ADD:  nxt = cur + operand;
            OP_SUB:  nxt = cur - operand;
            default: upd = 1'b0;
        endcase
    end
endmodule

// File: rtl/evsem_nonzero.sv
module evsem_nonzero
    import evsem_pkg::*;
(
    input  logic [N_ENT-1:0][DW-1:0] sem,
    output logic [N_ENT-1:0]         nz
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_nz
        assign nz[g] = |sem[g];
    end
endmodule

// File: rtl/evsem_bank.sv
module evsem_bank
    import evsem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             bus_ready,
    output logic [N_ENT-1:0] evt_flags,
    output logic [N_ENT-1:0] sem_nonzero
);
    bank_state_t state_d, state_q;

    logic [IDX_W-1:0]         acc_idx;
    wr_op_t                   acc_wop;
    rd_sel_t                  acc_rsel;
    logic                     sem_upd;
    logic [DW-1:0]            sem_next;
    logic [N_ENT-1:0][DW-1:0] sem_cur;

    assign sem_cur = state_q.sem;

    evsem_decode u_dec (
        .req  (bus_req),
        .we   (bus_we),
        .addr (bus_addr),
        .idx  (acc_idx),
        .wop  (acc_wop),
        .rsel (acc_rsel)
    );

    evsem_arith u_alu (
        .wop     (acc_wop),
        .cur     (state_q.sem[acc_idx]),
        .operand (bus_wdata),
        .upd     (sem_upd),
        .nxt     (sem_next)
    );

    evsem_nonzero u_nz (
        .sem (sem_cur),
        .nz  (sem_nonzero)
    );

    always_comb begin
        state_d     = state_q;
        state_d.rdy = bus_req;
        if (acc_wop == OP_EVT) begin
            state_d.ev[acc_idx] = bus_wdata[0];
        end
        if (sem_upd) begin
            state_d.sem[acc_idx] = sem_next;
        end
        unique case (acc_rsel)
            RD_EVT:  state_d.rdata = {{(DW-1){1'b0}}, state_q.ev[acc_idx]};
            RD_SEM:  state_d.rdata = state_q.sem[acc_idx];
            default: state_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata = state_q.rdata;
    assign bus_ready = state_q.rdy;
    assign evt_flags = state_q.ev;
endmodule

// File: rtl/evsem_bank_chk.sv
module evsem_bank_chk
    import evsem_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_req,
    input logic                     bus_we,
    input logic [AW-1:0]            bus_addr,
    input logic [DW-1:0]            bus_wdata,
    input logic [DW-1:0]            bus_rdata,
    input logic                     bus_ready,
    input logic [N_ENT-1:0]         evt_flags,
    input logic [N_ENT-1:0][DW-1:0] sem_cur
);
    logic [WIN_W-1:0] c_win;
    logic [IDX_W-1:0] c_idx;
    logic             c_wr;
    logic             c_rd;

    assign c_win = bus_addr[AW-1 -: WIN_W];
    assign c_idx = bus_addr[IDX_W+1:2];
    assign c_wr  = bus_req && bus_we;
    assign c_rd  = bus_req && !bus_we;

    assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ready);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ready);

    assert_add_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_win == 3'd6) |=>
        sem_cur[$past(c_idx)] == $past(sem_cur[c_idx]) + $past(bus_wdata));

    assert_sub_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_win == 3'd7) |=>
        sem_cur[$past(c_idx)] == $past(sem_cur[c_idx]) - $past(bus_wdata));

    assert_ro_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_win == 3'd4) |=> ($stable(sem_cur) && $stable(evt_flags)));

    assert_rsvd_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && c_win >= 3'd1 && c_win <= 3'd3) |=>
        ($stable(sem_cur) && $stable(evt_flags)));

    assert_wo_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rd && c_win >= 3'd5) |=> bus_rdata == '0);
endmodule

bind evsem_bank evsem_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .evt_flags (evt_flags),
    .sem_cur   (sem_cur)
);

// File: tb/sim_evsem_bank.sv
module sim_evsem_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0;
    logic         bus_we = 1'b0;
    logic [12:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         bus_ready;
    logic [255:0] evt_flags;
    logic [255:0] sem_nonzero;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    evsem_bank u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req     (bus_req),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_ready   (bus_ready),
        .evt_flags   (evt_flags),
        .sem_nonzero (sem_nonzero)
    );

    // Vector fields: {we, addr[12:0], wdata[31:0], expected rdata[31:0]}
    localparam int NV = 29;
    localparam logic [77:0] VEC [NV] = '{
        {1'b0, 13'h1000, 32'h0,        32'h0},        // R11 counter 0 starts at zero
        {1'b1, 13'h1400, 32'h5,        32'h0},        // R4 overwrite
        {1'b0, 13'h1000, 32'h0,        32'h5},        // R4 R7
        {1'b1, 13'h1800, 32'h3,        32'h0},        // R5 add
        {1'b0, 13'h1000, 32'h0,        32'h8},        // R5 R10 read next cycle
        {1'b1, 13'h1C00, 32'h2,        32'h0},        // R6 subtract
        {1'b0, 13'h1000, 32'h0,        32'h6},        // R7
        {1'b1, 13'h1C04, 32'h1,        32'h0},        // R6 wrap below zero
        {1'b0, 13'h1004, 32'h0,        32'hFFFFFFFF}, // R6
        {1'b1, 13'h1804, 32'h2,        32'h0},        // R5 wrap above max
        {1'b0, 13'h1004, 32'h0,        32'h1},        // R5
        {1'b1, 13'h17FC, 32'hA5,       32'h0},        // R4 last entry
        {1'b1, 13'h13FC, 32'h7,        32'h0},        // R3 write to read window
        {1'b0, 13'h13FC, 32'h0,        32'hA5},       // R3
        {1'b0, 13'h17FC, 32'h0,        32'h0},        // R9
        {1'b0, 13'h1BFC, 32'h0,        32'h0},        // R9
        {1'b0, 13'h1FFC, 32'h0,        32'h0},        // R9
        {1'b1, 13'h0008, 32'h1,        32'h0},        // R2 set
        {1'b0, 13'h0008, 32'h0,        32'h1},        // R2
        {1'b1, 13'h0008, 32'hFFFFFFFE, 32'h0},        // R2 clear via bit 0
        {1'b0, 13'h0008, 32'h0,        32'h0},        // R2
        {1'b1, 13'h03FF, 32'h3,        32'h0},        // R2 R1 low bits ignored
        {1'b0, 13'h03FC, 32'h0,        32'h1},        // R2
        {1'b1, 13'h0400, 32'h1,        32'h0},        // R8 reserved write
        {1'b0, 13'h0400, 32'h0,        32'h0},        // R8 reserved read
        {1'b1, 13'h0FFC, 32'hFFFFFFFF, 32'h0},        // R8 aliases entry 255
        {1'b0, 13'h03FC, 32'h0,        32'h1},        // R8 flag kept
        {1'b0, 13'h13FC, 32'h0,        32'hA5},       // R8 counter kept
        {1'b0, 13'h1000, 32'h0,        32'h6}         // R1 entry 0 untouched
    };
    localparam int VREQ [NV] = '{11,4,4,5,5,6,7,6,6,5,5,4,3,3,9,9,9,
                                 2,2,2,2,2,2,8,8,8,8,8,1};

    task automatic check(input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Caller is at a falling edge; returns at the next falling edge.
    task automatic access(input logic we, input logic [12:0] a,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic rdy);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = wd;
        @(negedge clk);
        rd  = bus_rdata;
        rdy = bus_ready;
        bus_req = 1'b0;
        bus_we  = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic        rdy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 flags after reset", evt_flags, '0);
        check("R11 nonzero after reset", sem_nonzero, '0);
        check("R10 idle ready", bus_ready, 0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][77], VEC[i][76:64], VEC[i][63:32], rd, rdy);
            check($sformatf("R10 ready vec %0d", i), rdy, 1);
            check($sformatf("R%0d vec %0d", VREQ[i], i), rd, VEC[i][31:0]);
        end

        @(negedge clk);
        check("R10 ready drops when idle", bus_ready, 0);
        // R11 nonzero vector: entries 0, 1, 255 hold 6, 1, 0xA5
        check("R11 nonzero map", sem_nonzero,
              (256'd1 << 255) | 256'd3);
        // R2 flag vector: only entry 255 set
        check("R2 flag vector", evt_flags, 256'd1 << 255);

        // R6 R11 counter 1 back to zero clears its status bit
        access(1'b1, 13'h1C04, 32'h1, rd, rdy);
        check("R11 nonzero after drain", sem_nonzero,
              (256'd1 << 255) | 256'd1);
        access(1'b0, 13'h1004, 32'h0, rd, rdy);
        check("R6 drained counter", rd, 0);

        // R11 reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 flags after second reset", evt_flags, '0);
        check("R11 nonzero after second reset", sem_nonzero, '0);
        access(1'b0, 13'h13FC, 32'h0, rd, rdy);
        check("R11 counter 255 after reset", rd, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule